// File: doc/BRIEF.md
# Idle Wakeup Interval Timer

This block is a free-running 16-bit down-counter clocked by the instruction-cycle enable. Software can neither load nor read it. The counter keeps running in every power state. Each time counter bit 12 changes value, which happens once every 4096 enabled cycles, the block latches a pending flag. A separate enable bit decides whether that flag reaches the interrupt output.

The same bit-12 event also produces a one-cycle wakeup strobe, which the power controller uses to leave the idle state. The level of bit 12 is brought out as a tap for a watchdog to use.

Software clears the pending flag with a write strobe. Software writes the enable bit through a write-enable and data pair.

Top module: `idle_wake_timer`

## Requirements
- R1: After reset, `pend_o`, `irq_o` and `wake_o` are 0 and `tap_o` is 1, because the count resets to all ones.
- R2: The count decrements only in cycles where `cyc_en_i` is 1. The first bit-12 event follows the 4096th enabled cycle after reset, and each later event follows a further 4096 enabled cycles.
- R3: A bit-12 event sets `pend_o` at that clock edge. `pend_o` then stays 1 until it is cleared.
- R4: A `clr_pend_i` pulse in a cycle without an event clears `pend_o` at that edge.
- R5: If an event and `clr_pend_i` fall in the same cycle, `pend_o` is 1 afterwards.
- R6: `irq_o` is 1 exactly when `pend_o` is 1 and the enable bit is 1. With the enable bit at 0, `pend_o` still latches events.
- R7: When `en_we_i` is 1, the enable bit takes the value of `en_wdata_i` at that edge. Otherwise the enable bit holds its value.
- R8: `wake_o` is 1 for exactly the one cycle after each event edge, whatever the enable and pending state.
- R9: `tap_o` shows count bit 12. It starts at 1 and inverts at every event edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle enable; the count advances when high |
| clr_pend_i | input | 1 | Write strobe that clears the pending flag |
| en_we_i | input | 1 | Write strobe for the interrupt enable bit |
| en_wdata_i | input | 1 | New value for the interrupt enable bit |
| pend_o | output | 1 | Pending flag |
| irq_o | output | 1 | Interrupt request (pending and enabled) |
| wake_o | output | 1 | One-cycle idle exit strobe |
| tap_o | output | 1 | Level of count bit 12, for a watchdog |

## Verification
The count is hidden, so a corrupted count can only be seen through event timing. A wrong count shifts the next `wake_o` pulse and the next `tap_o` flip away from the 4096-enabled-cycle grid, and the error appears at the first event after the fault, within 4096 enabled cycles. A wrong pending or enable bit shows at once on `pend_o` and `irq_o`, in the cycle after the offending edge. The bench compares all four outputs against a model that only counts enabled cycles, and does so after every cycle. Directed cases put a clear on the exact event cycle and hold `cyc_en_i` low across what would otherwise be an event.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;
  parameter int unsigned CNT_W   = 16;
  parameter int unsigned TAP_BIT = 12;
endpackage

// File: rtl/idle_tmr_cnt.sv
module idle_tmr_cnt
  import idle_tmr_pkg::*;
#(
  parameter int unsigned W   = CNT_W,
  parameter int unsigned TAP = TAP_BIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  output logic tick_o,
  output logic tap_o
);
  localparam logic [W-1:0] RST_VAL = '1;
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= RST_VAL;
    else if (cyc_en_i) cnt_q <= cnt_q - ONE;
  end

  // bit TAP flips on the decrement that borrows through all lower bits
  assign tick_o = cyc_en_i && (cnt_q[TAP-1:0] == '0);
  assign tap_o  = cnt_q[TAP];

  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_en_i |=> cnt_q == $past(cnt_q) - ONE);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |=> $stable(cnt_q));
endmodule

// File: rtl/idle_tmr_flag.sv
module idle_tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_d_i,
  output logic pend_o,
  output logic irq_o,
  output logic wake_o
);
  logic pend_q, en_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (tick_i)     pend_q <= 1'b1;  // set beats clear
      else if (clr_i) pend_q <= 1'b0;
      if (en_we_i)    en_q   <= en_d_i;
      wake_q <= tick_i;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & en_q;
  assign wake_o = wake_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> pend_o);
  p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> !pend_o);
  p_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q));
  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

// File: rtl/idle_wake_timer.sv
module idle_wake_timer
  import idle_tmr_pkg::*;
#(
  parameter int unsigned W   = CNT_W,
  parameter int unsigned TAP = TAP_BIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  input  logic clr_pend_i,
  input  logic en_we_i,
  input  logic en_wdata_i,
  output logic pend_o,
  output logic irq_o,
  output logic wake_o,
  output logic tap_o
);
  logic tick;

  idle_tmr_cnt #(.W(W), .TAP(TAP)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cyc_en_i (cyc_en_i),
    .tick_o   (tick),
    .tap_o    (tap_o)
  );

  idle_tmr_flag i_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .clr_i   (clr_pend_i),
    .en_we_i (en_we_i),
    .en_d_i  (en_wdata_i),
    .pend_o  (pend_o),
    .irq_o   (irq_o),
    .wake_o  (wake_o)
  );

  p_wake_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> pend_o);
  p_tap_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> tap_o != $past(tap_o));
  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o);
endmodule

// File: tb/test_idle_wake_timer.sv
module test_idle_wake_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b0, clr_pend = 1'b0, en_we = 1'b0, en_wd = 1'b0;
  logic pend, irq, wake, tap;

  int unsigned checks = 0, errors = 0;
  int unsigned n = 0;
  bit m_pend = 0, m_en = 0, m_wake = 0;

  always #2.5 clk = ~clk;

  idle_wake_timer i_idle_wake_timer (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .clr_pend_i(clr_pend),
    .en_we_i(en_we), .en_wdata_i(en_wd),
    .pend_o(pend), .irq_o(irq), .wake_o(wake), .tap_o(tap)
  );

  function automatic bit exp_tap(int unsigned k);
    return ((k >> 12) & 1) == 0;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (enabled cycles %0d)", req, act, exp, n);
    end
  endtask

  task automatic step(bit c, bit clr, bit we, bit wd);
    bit ev;
    @(negedge clk);
    cyc_en = c; clr_pend = clr; en_we = we; en_wd = wd;
    @(posedge clk);
    ev = 0;
    if (c) begin n++; ev = (n % 4096 == 0); end
    if (ev) m_pend = 1; else if (clr) m_pend = 0;
    if (we) m_en = wd;
    m_wake = ev;
    #1;
    chk("R3/R4/R5 pend", pend, m_pend);
    chk("R6 irq", irq, m_pend & m_en);
    chk("R8 wake", wake, m_wake);
    chk("R2/R9 tap", tap, exp_tap(n));
  endtask

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d1e));
    #12;
    // R1 reset values
    chk("R1 pend", pend, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wake", wake, 1'b0);
    chk("R1 tap", tap, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R2 first event on 4096th enabled cycle, idle cycles in between
    for (int i = 0; i < 4095; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0);   // R2 no advance without enable
    chk("R2 no early pend", pend, 1'b0);
    step(1, 0, 0, 0);
    chk("R2 first event", wake, 1'b1);
    // R6 pending latched while disabled
    chk("R6 latched disabled", pend & ~irq, 1'b1);
    // R7 enable write, R6 irq follows
    step(0, 0, 1, 1);
    chk("R7 enable", irq, 1'b1);
    // R4 clear without event
    step(1, 1, 0, 0);
    chk("R4 cleared", pend, 1'b0);

    // R5 clear on the event cycle
    while (n % 4096 != 4095) step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    chk("R5 set wins", pend, 1'b1);
    step(1, 1, 0, 0);

    // random mix
    for (int i = 0; i < 30000; i++) begin
      int unsigned r = $urandom;
      step((r & 3) != 0, (r >> 4) % 700 == 0, (r >> 14) % 900 == 0, r[31]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule